// File: doc/BRIEF.md
# Partitioned SIMD Integer Multiplier

This block multiplies two 64-bit unsigned operand words using a square array of sixteen 16×16-bit multiplier subblocks. A mode input reshapes the same array into one full 64×64 multiply, two independent 32×32 lane multiplies, or four independent 16×16 lane multiplies. Every lane's operands and results are packed into the same 64-bit words.

Each subblock multiplies one 16-bit chunk of operand A by one 16-bit chunk of operand B. The subblocks the selected mode needs are enabled. All the others see zero operands, so they do not toggle. A weighted adder aligns the subblock products by their chunk positions and sums them. Because idle subblocks contribute zero, lane results fall into place side by side with no carry between lanes.

The block has a two-stage pipeline: subblock products are registered first, and the summed result second. The mode travels with the operands, so it may change on every accepted input.

Top module: `pmul_top`

## Requirements
- R1: While reset is asserted, and after its release until a result is produced, out_valid is 0 and out_lo, out_hi and out_en are all zero.
- R2: With in_mode = 2'b10 (full), {out_hi, out_lo} equals the 128-bit unsigned product in_a × in_b.
- R3: With in_mode = 2'b01 (two lanes), out_lo = in_a[31:0] × in_b[31:0] and out_hi = in_a[63:32] × in_b[63:32]. Each is a 64-bit product, and no carry passes between the two.
- R4: With in_mode = 2'b00 (four lanes), out_lo[31:0] = a[15:0]×b[15:0], out_lo[63:32] = a[31:16]×b[31:16], out_hi[31:0] = a[47:32]×b[47:32] and out_hi[63:32] = a[63:48]×b[63:48].
- R5: in_mode = 2'b11 is reserved. It enables no subblock, and the result is zero on both output words.
- R6: Bit 4·i+j of out_en marks subblock (A chunk i, B chunk j) as active for the reported result. The values are 16'h8421 in four-lane mode, 16'hCC33 in two-lane mode, 16'hFFFF in full mode and 16'h0000 in the reserved mode.
- R7: A subblock that the mode leaves unused receives zero operands and holds a zero product.
- R8: A result appears with out_valid high exactly two clock cycles after its operands are accepted with in_valid high. Back-to-back inputs give back-to-back results.
- R9: Two cycles after a cycle with in_valid low, out_valid is low, and out_lo, out_hi and out_en keep their previous values.
- R10: The mode is captured together with its operands. A stream whose mode changes on every cycle returns each result computed in its own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and mode are presented this cycle |
| in_mode | input | 2 | 00 four lanes, 01 two lanes, 10 full, 11 reserved |
| in_a | input | 64 | Operand A, lanes packed from bit 0 |
| in_b | input | 64 | Operand B, lanes packed from bit 0 |
| out_valid | output | 1 | Result words are new this cycle |
| out_lo | output | 64 | Low result word |
| out_hi | output | 64 | High result word |
| out_en | output | 16 | Subblocks that were active for this result |

## Verification
Every accepted input has its result, its enable vector and its out_valid due two rising edges after the edge that samples it. The bench drives on the falling edge and keeps a two-entry shadow pipeline of what it drove. On each falling edge it compares the outputs with the entry driven two falling edges earlier. When that entry was an idle cycle, the bench expects out_valid low and the outputs unchanged from the last result. Expected products come from wide unsigned multiplies of the lane fields, computed separately from the chunk array.

// File: rtl/pmul_pkg.sv
// Package: shared parameters, mode encoding and mask helpers for the
// partitioned multiplier. Assumes a square chunk array (NCH x NCH).
package pmul_pkg;

    typedef enum logic [1:0] {
        PM_LANE16 = 2'b00,
        PM_LANE32 = 2'b01,
        PM_FULL64 = 2'b10,
        PM_OFF    = 2'b11
    } pm_mode_e;

    // Builds the active-subblock mask for lanes that are g chunks wide.
    // Subblock k = i*nch + j is active when chunks i and j share a lane.
    function automatic logic [63:0] pm_lane_mask(input int nch, input int g);
        logic [63:0] m;
        m = '0;
        if (g > 0) begin
            for (int i = 0; i < nch; i++) begin
                for (int j = 0; j < nch; j++) begin
                    if ((i / g) == (j / g)) m[i*nch + j] = 1'b1;
                end
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/pmul_gate.sv
// Module: decodes the mode into a subblock enable mask and forces the
// operands of every disabled subblock to zero so that it stays idle.
// Assumes the reserved mode enables nothing.
module pmul_gate
    import pmul_pkg::*;
#(
    parameter int LW  = 16,
    parameter int NCH = 4
) (
    input  logic [1:0]                  mode,
    input  logic [LW*NCH-1:0]           a,
    input  logic [LW*NCH-1:0]           b,
    output logic [NCH*NCH-1:0]          en,
    output logic [NCH*NCH-1:0][LW-1:0]  sub_a,
    output logic [NCH*NCH-1:0][LW-1:0]  sub_b
);
    localparam int NSUB = NCH * NCH;
    localparam logic [63:0] MASK_Q = pm_lane_mask(NCH, 1);
    localparam logic [63:0] MASK_D = pm_lane_mask(NCH, 2);
    localparam logic [63:0] MASK_F = pm_lane_mask(NCH, NCH);

    // Select the active mask for the current mode.
    always_comb begin
        unique case (pm_mode_e'(mode))
            PM_LANE16: en = MASK_Q[NSUB-1:0];
            PM_LANE32: en = MASK_D[NSUB-1:0];
            PM_FULL64: en = MASK_F[NSUB-1:0];
            default:   en = '0;
        endcase
    end

    // Route chunk i of A and chunk j of B to subblock i*NCH+j, zero if idle.
    for (genvar i = 0; i < NCH; i++) begin : g_row
        for (genvar j = 0; j < NCH; j++) begin : g_col
            assign sub_a[i*NCH+j] = en[i*NCH+j] ? a[i*LW +: LW] : '0;
            assign sub_b[i*NCH+j] = en[i*NCH+j] ? b[j*LW +: LW] : '0;
        end
    end
endmodule

// File: rtl/pmul_sub.sv
// Module: one 16x16 unsigned multiplier subblock with a registered product.
// Loads only when a new input is accepted; idle subblocks load zero.
module pmul_sub #(
    parameter int LW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld,
    input  logic [LW-1:0]   a,
    input  logic [LW-1:0]   b,
    output logic [2*LW-1:0] prod
);
    logic [2*LW-1:0] wa, wb;

    // Widen both operands to the full product width.
    always_comb begin
        wa = (2*LW)'(a);
        wb = (2*LW)'(b);
    end

    // Stage-1 product register, enabled only on accepted inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)  prod <= '0;
        else if (ld) prod <= wa * wb;
    end
endmodule

// File: rtl/pmul_sum.sv
// Module: aligns each subblock product by 16*(i+j) bits and sums them.
// Assumes idle subblocks hold zero, so that lane results land side by side
// without overlap.
module pmul_sum #(
    parameter int LW  = 16,
    parameter int NCH = 4
) (
    input  logic [NCH*NCH-1:0][2*LW-1:0] prod,
    output logic [2*LW*NCH-1:0]          total
);
    localparam int NSUB = NCH * NCH;
    localparam int PW   = 2 * LW * NCH;

    // Weighted sum of all subblock products.
    always_comb begin
        total = '0;
        for (int k = 0; k < NSUB; k++) begin
            total = total + (PW'(prod[k]) << (LW * ((k / NCH) + (k % NCH))));
        end
    end
endmodule

// File: rtl/pmul_top.sv
// Module: partitioned SIMD multiplier top. Stage 1 gates operands and
// registers subblock products with the mode mask. Stage 2 registers the
// aligned sum. Outputs hold between results.
module pmul_top
    import pmul_pkg::*;
#(
    parameter int LW  = 16,
    parameter int NCH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [1:0]            in_mode,
    input  logic [LW*NCH-1:0]     in_a,
    input  logic [LW*NCH-1:0]     in_b,
    output logic                  out_valid,
    output logic [LW*NCH-1:0]     out_lo,
    output logic [LW*NCH-1:0]     out_hi,
    output logic [NCH*NCH-1:0]    out_en
);
    localparam int W    = LW * NCH;
    localparam int NSUB = NCH * NCH;

    logic [NSUB-1:0]           en0;
    logic [NSUB-1:0][LW-1:0]   sa, sb;
    logic [NSUB-1:0][2*LW-1:0] prod1;
    logic [NSUB-1:0]           en1;
    logic                      v1;
    logic [2*W-1:0]            total;

    pmul_gate #(.LW(LW), .NCH(NCH)) u_gate (
        .mode (in_mode),
        .a    (in_a),
        .b    (in_b),
        .en   (en0),
        .sub_a(sa),
        .sub_b(sb)
    );

    for (genvar k = 0; k < NSUB; k++) begin : g_sub
        pmul_sub #(.LW(LW)) u_sub (
            .clk  (clk),
            .rst_n(rst_n),
            .ld   (in_valid),
            .a    (sa[k]),
            .b    (sb[k]),
            .prod (prod1[k])
        );
    end

    // Stage-1 control: valid and the enable mask travel with the products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1  <= 1'b0;
            en1 <= '0;
        end else begin
            v1 <= in_valid;
            if (in_valid) en1 <= en0;
        end
    end

    pmul_sum #(.LW(LW), .NCH(NCH)) u_sum (
        .prod (prod1),
        .total(total)
    );

    // Stage-2 result register; holds when no result is due.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_lo    <= '0;
            out_hi    <= '0;
            out_en    <= '0;
        end else begin
            out_valid <= v1;
            if (v1) begin
                out_lo <= total[W-1:0];
                out_hi <= total[2*W-1:W];
                out_en <= en1;
            end
        end
    end
endmodule

// File: rtl/pmul_chk.sv
// Checker: timing, hold and gating properties of pmul_top, bound below.
module pmul_chk #(
    parameter int NSUB = 16,
    parameter int PWS  = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic                      out_valid,
    input logic [63:0]               out_lo,
    input logic [63:0]               out_hi,
    input logic [NSUB-1:0]           out_en,
    input logic [NSUB-1:0]           s1_en,
    input logic [NSUB-1:0][PWS-1:0]  s1_prod
);
    // R8
    lat_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R9
    idle_novalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 ($stable(out_lo) && $stable(out_hi) && $stable(out_en)));

    // R6
    en_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_en == 16'h8421 || out_en == 16'hCC33 ||
                       out_en == 16'hFFFF || out_en == 16'h0000));

    // R5
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_en == '0) |-> (out_lo == '0 && out_hi == '0));

    for (genvar k = 0; k < NSUB; k++) begin : g_gate
        // R7
        idle_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !s1_en[k] |-> (s1_prod[k] == '0));
    end
endmodule

bind pmul_top pmul_chk #(.NSUB(16), .PWS(32)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_lo   (out_lo),
    .out_hi   (out_hi),
    .out_en   (out_en),
    .s1_en    (en1),
    .s1_prod  (prod1)
);

// File: tb/tb_pmul_top.sv
`timescale 1ns/1ps
module tb_pmul_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  in_mode;
    logic [63:0] in_a, in_b;
    logic        out_valid;
    logic [63:0] out_lo, out_hi;
    logic [15:0] out_en;

    int n_chk = 0;
    int n_bad = 0;

    // Shadow pipeline of driven stimulus, index 1 is the entry due now.
    logic        rv [2];
    logic [1:0]  rm [2];
    logic [63:0] ra [2];
    logic [63:0] rb [2];
    logic [63:0] last_lo = '0, last_hi = '0;
    logic [15:0] last_en = '0;

    always #2 clk = ~clk;

    pmul_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_lo(out_lo), .out_hi(out_hi), .out_en(out_en)
    );

    function automatic logic [127:0] ref_prod(input logic [1:0] m,
                                             input logic [63:0] a,
                                             input logic [63:0] b);
        logic [127:0] r;
        r = '0;
        case (m)
            2'b10: r = {64'b0, a} * {64'b0, b};
            2'b01: begin
                r[63:0]   = {32'b0, a[31:0]}  * {32'b0, b[31:0]};
                r[127:64] = {32'b0, a[63:32]} * {32'b0, b[63:32]};
            end
            2'b00: begin
                for (int l = 0; l < 4; l++)
                    r[l*32 +: 32] = {16'b0, a[l*16 +: 16]} * {16'b0, b[l*16 +: 16]};
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [15:0] ref_en(input logic [1:0] m);
        case (m)
            2'b00:   return 16'h8421;
            2'b01:   return 16'hCC33;
            2'b10:   return 16'hFFFF;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'b10:   return "R2";
            2'b01:   return "R3";
            2'b00:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Compare the due entry at the falling edge, shift, then drive the new input.
    task automatic step(input logic v, input logic [1:0] m,
                        input logic [63:0] a, input logic [63:0] b);
        logic [127:0] e;
        @(negedge clk);
        if (rv[1]) begin
            e = ref_prod(rm[1], ra[1], rb[1]);
            chk("R8 valid", {127'b0, out_valid}, 128'd1);
            chk({mode_req(rm[1]), " R10 lo"}, {64'b0, out_lo}, {64'b0, e[63:0]});
            chk({mode_req(rm[1]), " R10 hi"}, {64'b0, out_hi}, {64'b0, e[127:64]});
            chk("R6 R7 en", {112'b0, out_en}, {112'b0, ref_en(rm[1])});
            last_lo = e[63:0];
            last_hi = e[127:64];
            last_en = ref_en(rm[1]);
        end else begin
            chk("R9 valid", {127'b0, out_valid}, 128'd0);
            chk("R9 hold", {out_hi, out_lo}, {last_hi, last_lo});
            chk("R9 hold en", {112'b0, out_en}, {112'b0, last_en});
        end
        rv[1] = rv[0]; rm[1] = rm[0]; ra[1] = ra[0]; rb[1] = rb[0];
        rv[0] = v;     rm[0] = m;     ra[0] = a;     rb[0] = b;
        in_valid = v; in_mode = m; in_a = a; in_b = b;
    endtask

    function automatic logic [63:0] r64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        #(4ns * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] seed_v;
        seed_v = $urandom(32'd20240611);
        rv[0] = 0; rv[1] = 0;
        rm[0] = '0; rm[1] = '0; ra[0] = '0; ra[1] = '0; rb[0] = '0; rb[1] = '0;
        rst_n = 1'b0; in_valid = 1'b0; in_mode = 2'b00; in_a = '0; in_b = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", {out_hi, out_lo}, '0);
        chk("R1 en/valid", {111'b0, out_en, out_valid}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 2'b00, '0, '0);
        step(0, 2'b00, '0, '0);   // R1 after release: still zero (held)
        // Directed corners: all ones per mode (lane carry boundaries)
        step(1, 2'b10, '1, '1);                       // R2
        step(1, 2'b01, '1, '1);                       // R3
        step(1, 2'b00, '1, '1);                       // R4
        step(1, 2'b11, '1, '1);                       // R5
        step(1, 2'b10, 64'h1, '1);                    // R2
        step(1, 2'b01, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_FFFF_FFFF); // R3
        step(1, 2'b00, 64'h0001_FFFF_0000_8000, 64'hFFFF_FFFF_1234_0002); // R4
        step(0, 2'b10, '1, '1);                       // R9 gap
        step(0, 2'b01, 64'h5, 64'h7);
        step(1, 2'b10, 64'h0, '1);
        // R10: random stream with mode changes and idle gaps
        for (int t = 0; t < 3000; t++) begin
            logic [1:0] m;
            logic v;
            m = 2'($urandom_range(0, 3));
            v = ($urandom_range(0, 5) != 0);
            step(v, m, r64(), r64());
        end
        step(0, 2'b00, '0, '0);
        step(0, 2'b00, '0, '0);
        step(0, 2'b00, '0, '0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule